// File: doc/BRIEF.md
# Bidirectional Complete-Cycle LFSR Address Generator

This block produces the address stream for a March-style memory self-test. A shift-register sequence with feedback replaces the usual binary counter. The feedback gets one correction: it flips whenever the lower N-1 bits of the register are all zero. That correction lets the register reach all 2^N values, the all-zero value among them. Each step runs either forward, giving the up order, or through the exact algebraic inverse of the forward step, giving the down order. Because the down step is the inverse, the down order walks the same cycle backwards.

Each address goes out serially, most significant bit first, over N clock cycles on a single line. That one line can be broadcast to several memories under test. A parallel copy of the address being shifted is also driven. `addr_valid` marks the cycle of the last bit of each address. `end_of_seq` additionally marks the last address of every pass of 2^N addresses. The direction input is sampled only at that pass boundary, and the new direction applies to the very next address. No cycle is lost and no address is repeated at a turnaround.

Top module: `updown_lfsr_agen`

## Requirements
- R1: While reset (synchronous, active low) is applied, `scan_out`, `addr_valid` and `end_of_seq` are 0 and `addr_par` equals the parameter `SEED` (all-zero by default).
- R2: The generator stays idle after reset, with outputs as in R1, until `start` is sampled high. The first address it emits is `SEED`. A `start` pulse while the generator is running has no effect.
- R3: Every address takes exactly N enabled cycles, and the next address starts in the following cycle. In the k-th cycle of an address (k = 0..N-1), `scan_out` equals bit N-1-k of `addr_par`, and `addr_par` holds its value for the whole address. `addr_valid` is 1 only in the cycle with k = N-1 while `en` is 1.
- R4: Every pass of 2^N consecutive addresses contains each N-bit value exactly once, zero included.
- R5: In a down pass (`dir_down` = 1 when sampled), each address is the predecessor, in up order, of the address before it. A forward step followed by a reverse step gives back the original address.
- R6: `end_of_seq` is 1 only together with `addr_valid`, on the 2^N-th address of a pass.
- R7: The pass direction is taken from `dir_down` only in the cycle where `end_of_seq` is 1, or where `start` begins a run. That direction governs the next address onward. Changes to `dir_down` at any other time have no effect. In an up pass, each address is the up-order successor of the one before.
- R8: Two consecutive addresses are never equal, including across a turnaround between up and down passes.
- R9: While `en` is 0, nothing advances: `scan_out` and `addr_par` hold their values and `addr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable; when low, the generator stalls |
| dir_down | input | 1 | Requested order for the next pass: 0 up, 1 down |
| start | input | 1 | Begins generation when idle |
| scan_out | output | 1 | Serial address bit, MSB first |
| addr_par | output | N | Address currently being shifted out |
| addr_valid | output | 1 | Last bit of an address is on `scan_out` |
| end_of_seq | output | 1 | Last address of the current pass is complete |

## Verification
`addr_valid`, `end_of_seq` and `scan_out` are combinational from state and `en`, so they are due in the same cycle as the bit they describe. `addr_par` moves to the next address one rising edge after a cycle with `addr_valid`. A direction sampled on an `end_of_seq` edge must therefore appear in the very next address. A `start` sampled on an edge makes the first bit of `SEED` due in the cycle after that edge. The bench drives inputs just after each rising edge and samples at the falling edge. Its behavioural model advances with the same inputs, so every output is compared in the exact cycle it is due. Address order is checked against a successor table learned from the observed passes, never against a copy of the feedback logic.

// File: rtl/ulfsr_pkg.sv
// Package: shared constants for the bidirectional complete-cycle address generator.
// Assumes the address width lies in 2..11; other widths fall back to the 4-bit taps.
package ulfsr_pkg;

    // Lower feedback taps (bits 0..N-2) of a primitive polynomial for a left-shifting register
    function automatic logic [31:0] tap_mask(int unsigned width);
        case (width)
            2:       return 32'h0000_0001;
            3:       return 32'h0000_0002;
            4:       return 32'h0000_0004;
            5:       return 32'h0000_0004;
            6:       return 32'h0000_0010;
            7:       return 32'h0000_0020;
            8:       return 32'h0000_0038;
            9:       return 32'h0000_0010;
            10:      return 32'h0000_0040;
            11:      return 32'h0000_0100;
            default: return 32'h0000_0004;
        endcase
    endfunction

endpackage

// File: rtl/ulfsr_step.sv
// Module: ulfsr_step
// Computes the forward and the reverse successor of an address in a single
// complete-cycle feedback shift sequence. The forward step shifts left and
// appends the feedback bit. The feedback is inverted when the low N-1 bits are
// zero, which splices the all-zero state into the maximal cycle. The reverse
// step shifts right and rebuilds the dropped MSB from the same taps, so it is
// the exact inverse of the forward step.
// Assumes N >= 2 and a primitive tap set from ulfsr_pkg.
module ulfsr_step #(
    parameter int N = 4
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt_up,
    output logic [N-1:0] nxt_dn
);
    import ulfsr_pkg::*;

    localparam logic [31:0]  TAP_WORD = tap_mask(N);
    localparam logic [N-2:0] TAPS     = TAP_WORD[N-2:0];

    logic [N-2:0] low_bits;
    logic [N-2:0] high_bits;
    logic         fb_fwd;
    logic         msb_rev;

    // Forward step: feedback from the MSB and taps, corrected at the zero splice
    always_comb begin
        low_bits = cur[N-2:0];
        fb_fwd   = cur[N-1] ^ (^(low_bits & TAPS)) ^ (low_bits == '0);
        nxt_up   = {low_bits, fb_fwd};
    end

    // Reverse step: recover the MSB that the forward step shifted out
    always_comb begin
        high_bits = cur[N-1:1];
        msb_rev   = cur[0] ^ (^(high_bits & TAPS)) ^ (high_bits == '0);
        nxt_dn    = {msb_rev, high_bits};
    end

endmodule

// File: rtl/ulfsr_shifter.sv
// Module: ulfsr_shifter
// Serialises the current address MSB first over N enabled cycles and flags
// the cycle of the last bit. Assumes the caller changes the address only on
// the cycle after last_bit was high with en set.
module ulfsr_shifter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         en,
    input  logic [N-1:0] addr,
    output logic         scan_out,
    output logic         last_bit
);
    localparam int IW = (N > 2) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    logic [IW-1:0] bit_idx;
    logic [N-1:0]  aligned;

    // Bit position counter: advances on every enabled running cycle, wraps after the LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (run && en) begin
            bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
        end
    end

    // Output selection: present the bit under the counter, silent while idle
    always_comb begin
        aligned  = addr << bit_idx;
        scan_out = run & aligned[N-1];
        last_bit = run & (bit_idx == LAST_IDX);
    end

    AST_SINGLE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && en) |=> !last_bit) else $error("last bit repeated"); // R3

endmodule

// File: rtl/ulfsr_pass_ctl.sv
// Module: ulfsr_pass_ctl
// Tracks the run state, the address count within a pass and the pass direction.
// The direction input is sampled when a run starts and on the last address of
// each pass, and dir_next gives the direction for the upcoming address step.
// Assumes step pulses only while running.
module ulfsr_pass_ctl #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir_down,
    input  logic step,
    output logic run,
    output logic pass_last,
    output logic dir_next
);
    logic [N-1:0] addr_cnt;
    logic         pass_dir;

    // Run, count and direction state: start arms the run, steps count addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            addr_cnt <= '0;
            pass_dir <= 1'b0;
        end else if (start && !run) begin
            run      <= 1'b1;
            addr_cnt <= '0;
            pass_dir <= dir_down;
        end else if (step) begin
            addr_cnt <= addr_cnt + 1'b1;
            if (pass_last) begin
                pass_dir <= dir_down;
            end
        end
    end

    // Boundary decode and direction for the step about to be taken
    always_comb begin
        pass_last = run & (addr_cnt == '1);
        dir_next  = pass_last ? dir_down : pass_dir;
    end

    AST_DIR_HELD_MID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !(step && pass_last)) |=> $stable(pass_dir)) else $error("direction moved mid pass"); // R7

    AST_STEP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> run) else $error("step while idle"); // R2

endmodule

// File: rtl/updown_lfsr_agen.sv
// Module: updown_lfsr_agen (top)
// Serial address generator for memory self-test. It holds the current address,
// steps it forward or backward through a complete 2^N cycle after each address
// has been shifted out, and flags the end of every pass of 2^N addresses.
// Assumes N in 2..11; SEED is the first address emitted after reset and start.
module updown_lfsr_agen #(
    parameter int          N    = 4,
    parameter logic [N-1:0] SEED = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         dir_down,
    input  logic         start,
    output logic         scan_out,
    output logic [N-1:0] addr_par,
    output logic         addr_valid,
    output logic         end_of_seq
);
    logic [N-1:0] cur_addr;
    logic [N-1:0] nxt_up;
    logic [N-1:0] nxt_dn;
    logic         run;
    logic         last_bit;
    logic         pass_last;
    logic         dir_next;

    ulfsr_step #(.N(N)) u_step (
        .cur    (cur_addr),
        .nxt_up (nxt_up),
        .nxt_dn (nxt_dn)
    );

    ulfsr_shifter #(.N(N)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .en       (en),
        .addr     (cur_addr),
        .scan_out (scan_out),
        .last_bit (last_bit)
    );

    ulfsr_pass_ctl #(.N(N)) u_pass (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dir_down  (dir_down),
        .step      (addr_valid),
        .run       (run),
        .pass_last (pass_last),
        .dir_next  (dir_next)
    );

    // Completion strobes: an address is done when its last bit is shifted with en high
    always_comb begin
        addr_valid = run & en & last_bit;
        end_of_seq = addr_valid & pass_last;
        addr_par   = cur_addr;
    end

    // Address register: load the seed in reset, step once per completed address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= SEED;
        end else if (addr_valid) begin
            cur_addr <= dir_next ? nxt_dn : nxt_up;
        end
    end

    AST_REV_UNDOES_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !dir_next) |=> (nxt_dn == $past(cur_addr))) else $error("reverse step not inverse"); // R5

    AST_FWD_UNDOES_REV: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && dir_next) |=> (nxt_up == $past(cur_addr))) else $error("forward step not inverse"); // R5

    AST_ADDR_ALWAYS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> (addr_par != $past(addr_par))) else $error("address repeated"); // R8

    AST_EOS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_seq |-> addr_valid) else $error("end flag without valid"); // R6

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !en) |=> ($stable(addr_par) && $stable(scan_out))) else $error("stall moved output"); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!scan_out && !addr_valid && addr_par == SEED)) else $error("idle output active"); // R2

endmodule

// File: tb/updown_lfsr_agen_bench.sv
// Bench: behavioural model of the serial pass/bit timing plus a learned
// successor table, compared at every falling edge.
module updown_lfsr_agen_bench;
    localparam int N  = 4;
    localparam int NA = 1 << N;
    localparam logic [N-1:0] SEED = '0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         dir_down = 1'b0;
    logic         start = 1'b0;
    logic         scan_out;
    logic [N-1:0] addr_par;
    logic         addr_valid;
    logic         end_of_seq;

    updown_lfsr_agen #(.N(N), .SEED(SEED)) u_updown_lfsr_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .dir_down   (dir_down),
        .start      (start),
        .scan_out   (scan_out),
        .addr_par   (addr_par),
        .addr_valid (addr_valid),
        .end_of_seq (end_of_seq)
    );

    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state
    bit           m_run = 0;
    int           m_bit = 0;
    int           m_cnt = 0;
    int           m_dir = 0;
    int           m_pass = 0;
    int           turns = 0;
    bit           first_addr = 1;
    bit           have_prev = 0;
    logic [N-1:0] prev_a = '0;
    logic [N-1:0] word_hold = '0;
    bit           seen [NA];
    bit           known [NA];
    logic [N-1:0] succ [NA];
    bit           stalled = 0;
    logic [N-1:0] st_par = '0;
    logic         st_scan = 1'b0;
    int           plan [6] = '{0, 1, 1, 0, 1, 0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic addr_done(input logic [N-1:0] a);
        int cnt_seen;
        if (first_addr) begin
            chk(a == SEED, "R2 first address", int'(a), int'(SEED));
            first_addr = 0;
        end
        chk(!seen[int'(a)], "R4 duplicate in pass", int'(a), -1);
        seen[int'(a)] = 1;
        if (have_prev) begin
            chk(a != prev_a, "R8 repeat", int'(a), int'(prev_a));
            if (m_dir == 0) begin
                if (known[int'(prev_a)]) chk(succ[int'(prev_a)] == a, "R7 up order", int'(a), int'(succ[int'(prev_a)]));
                else begin known[int'(prev_a)] = 1; succ[int'(prev_a)] = a; end
            end else begin
                if (known[int'(a)]) chk(succ[int'(a)] == prev_a, "R5 down order", int'(prev_a), int'(succ[int'(a)]));
                else begin known[int'(a)] = 1; succ[int'(a)] = prev_a; end
            end
        end
        prev_a = a;
        have_prev = 1;
        if (m_cnt == NA - 1) begin
            cnt_seen = 0;
            for (int i = 0; i < NA; i++) begin
                if (seen[i]) cnt_seen++;
                seen[i] = 0;
            end
            chk(cnt_seen == NA, "R4 pass coverage", cnt_seen, NA);
        end
    endtask

    // compare outputs with the model, then advance the model by the pending inputs
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(!scan_out && !addr_valid && !end_of_seq, "R1 outputs in reset",
                int'({scan_out, addr_valid, end_of_seq}), 0);
            chk(addr_par == SEED, "R1 seed in reset", int'(addr_par), int'(SEED));
            m_run = 0; m_bit = 0; m_cnt = 0; m_dir = 0; stalled = 0;
        end else begin
            if (m_run) begin
                chk(addr_valid == (en && m_bit == N - 1), "R3 valid timing", int'(addr_valid), int'(en && m_bit == N - 1));
                chk(end_of_seq == (en && m_bit == N - 1 && m_cnt == NA - 1), "R6 end flag",
                    int'(end_of_seq), int'(en && m_bit == N - 1 && m_cnt == NA - 1));
                chk(scan_out == addr_par[N - 1 - m_bit], "R3 serial bit", int'(scan_out), int'(addr_par[N - 1 - m_bit]));
                if (m_bit == 0) word_hold = addr_par;
                else chk(addr_par == word_hold, "R3 address held", int'(addr_par), int'(word_hold));
                if (stalled) begin
                    chk(addr_par == st_par, "R9 stall address", int'(addr_par), int'(st_par));
                    chk(scan_out == st_scan, "R9 stall bit", int'(scan_out), int'(st_scan));
                end
                if (!en) chk(!addr_valid, "R9 no valid when stalled", int'(addr_valid), 0);
                if (en && m_bit == N - 1) addr_done(word_hold);
            end else begin
                chk(!scan_out && !addr_valid && !end_of_seq, "R2 idle outputs",
                    int'({scan_out, addr_valid, end_of_seq}), 0);
                chk(addr_par == SEED, "R2 idle address", int'(addr_par), int'(SEED));
            end
            stalled = m_run && !en;
            st_par  = addr_par;
            st_scan = scan_out;
            if (start && !m_run) begin
                m_run = 1; m_bit = 0; m_cnt = 0; m_dir = int'(dir_down);
            end else if (m_run && en) begin
                if (m_bit == N - 1) begin
                    m_bit = 0;
                    if (m_cnt == NA - 1) begin
                        m_cnt = 0;
                        if (m_dir != int'(dir_down)) turns++;
                        m_dir = int'(dir_down);
                        m_pass++;
                    end else m_cnt++;
                end else m_bit++;
            end
        end
    end

    initial begin
        for (int i = 0; i < NA; i++) begin seen[i] = 0; known[i] = 0; succ[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1 start = 1'b1; dir_down = 1'b0; en = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int c = 0; c < 700; c++) begin
            en = ((c % 9) != 4);
            if (m_run && m_cnt == NA - 1) dir_down = plan[(m_pass + 1) % 6] != 0;
            else dir_down = ((c % 6) < 3);    // mid-pass noise, R7 says ignored
            start = (c == 150);               // R2: ignored while running
            @(posedge clk);
            #1;
        end
        chk(turns >= 3, "R7 turnarounds seen", turns, 3);
        chk(m_pass >= 6, "R6 passes completed", m_pass, 6);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule